// File: doc/BRIEF.md
# PCI Interrupt Swizzle Router

This block collects the interrupt pins of three expansion slots and one on-board SCSI controller and presents them as ISA interrupt requests. The slot pins are first folded into three shared request channels by a fixed rotation: the pin letter shifts the channel, so the same letter on neighbouring slots lands on different channels. Within a channel the requests are combined as a wired-OR. A fourth channel carries only the SCSI controller.

Each channel has a route register. It holds an enable bit and a 4-bit ISA line number, and it decides which line, if any, the channel drives. Software programs the registers through a simple write and read port. A write that names a line outside the permitted set is dropped. The routed requests are level-sensitive and active-high, and they are registered once before they leave the block. Priority resolution among the ISA lines belongs to the interrupt controller that follows.

Top module: `pirq_router`

## Requirements
- R1: Slot pin bit index is slot*4 + pin (pin 0..3 = A..D, slots 0..2). A pin that is low asserts channel (slot - pin) mod 3. Channel 0 takes bits 0, 3, 5 and 10. Channel 1 takes bits 2, 4, 7 and 9. Channel 2 takes bits 1, 6, 8 and 11. Several asserted pins on one channel combine as an OR.
- R2: Channel 3 is asserted only when `scsi_int_n` is low. No slot pin reaches channel 3.
- R3: A route register holds bit 4 = enable and bits 3:0 = target ISA line. `cfg_addr` selects the channel for both writes and reads. An accepted write takes effect at the clock edge where `cfg_we` is high, and `cfg_rdata` shows the selected register combinationally.
- R4: While `rst_n` is low (asynchronous, active-low), every route register reads 0 and `irq_req` is 0.
- R5: Only lines 5, 9, 10, 14 and 15 are legal targets. A write naming any other line is ignored entirely, including its enable bit.
- R6: While `ide_on` is high, a write naming line 14 is ignored. A channel already routed to 14 does not drive `irq_req[14]` from the clock edge after `ide_on` rises.
- R7: A channel whose enable bit is 0 drives no line.
- R8: Channels routed to the same line are ORed onto it.
- R9: `irq_req` bits for lines 2, 8 and 13, and for any other line outside the legal set, are always 0.
- R10: `irq_req` is registered. It changes at the first rising clock edge after a source changes, and it follows the source level, dropping when the source is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_int_n | input | 12 | Slot interrupt pins, active-low, index slot*4+pin |
| scsi_int_n | input | 1 | On-board SCSI interrupt, active-low |
| ide_on | input | 1 | High while the IDE function owns line 14 |
| cfg_we | input | 1 | Route register write strobe |
| cfg_addr | input | 2 | Route register (channel) select |
| cfg_wdata | input | 5 | Write data {enable, line[3:0]} |
| cfg_rdata | output | 5 | Read data of the selected route register |
| irq_req | output | 16 | Active-high level ISA interrupt requests |

## Verification
Each of the twelve slot pins is asserted alone with the four channels routed to four distinct lines, so every pin's channel shows up as a distinct output bit and a wrong rotation cannot hide. SCSI alone, two pins of one channel together, and all sources at once check the dedicated channel and the OR within a channel. Directed runs program two channels onto one line, disable a channel, attempt illegal targets and line 14 under `ide_on`, and time the output against the clock edge, which separates a combinational path from the registered one.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

    localparam int DEF_NUM_SLOTS = 3;
    localparam int DEF_PINS      = 4;
    localparam int DEF_NUM_IRQ   = 16;
    // legal targets: 5, 9, 10, 14, 15
    localparam logic [DEF_NUM_IRQ-1:0] DEF_LEGAL_MASK = 16'hC620;
    localparam int DEF_IDE_LINE  = 14;

    // channel fed by a given slot pin: (slot - pin) mod number of slot channels
    function automatic int swz_chan(input int slot, input int pin, input int nch);
        return (((slot - pin) % nch) + nch) % nch;
    endfunction

endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
    import pirq_router_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int PINS      = DEF_PINS,
    localparam int NUM_CH   = NUM_SLOTS + 1,
    localparam int NUM_PIN  = NUM_SLOTS * PINS
) (
    input  logic [NUM_PIN-1:0] slot_int_n,
    input  logic               scsi_int_n,
    output logic [NUM_CH-1:0]  pirq
);

    for (genvar c = 0; c < NUM_SLOTS; c++) begin : g_chan
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                for (int p = 0; p < PINS; p++) begin
                    if (swz_chan(s, p, NUM_SLOTS) == c) begin
                        hit = hit | ~slot_int_n[s*PINS + p];
                    end
                end
            end
        end
        assign pirq[c] = hit;
    end

    // dedicated on-board channel
    assign pirq[NUM_SLOTS] = ~scsi_int_n;

endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int NUM_CH   = DEF_NUM_SLOTS + 1,
    parameter int NUM_IRQ  = DEF_NUM_IRQ,
    parameter logic [NUM_IRQ-1:0] LEGAL_MASK = DEF_LEGAL_MASK,
    parameter int IDE_LINE = DEF_IDE_LINE,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int LINE_W  = $clog2(NUM_IRQ),
    localparam int RW      = LINE_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ide_on,
    input  logic                     cfg_we,
    input  logic [CH_W-1:0]          cfg_addr,
    input  logic [RW-1:0]            cfg_wdata,
    output logic [RW-1:0]            cfg_rdata,
    output logic [NUM_CH-1:0]        route_en,
    output logic [NUM_CH*LINE_W-1:0] route_line
);

    logic [LINE_W-1:0] wr_line;
    logic              wr_legal;

    assign wr_line  = cfg_wdata[LINE_W-1:0];
    assign wr_legal = LEGAL_MASK[wr_line] &&
                      !(ide_on && (wr_line == LINE_W'(IDE_LINE)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
        logic              en_q;
        logic [LINE_W-1:0] line_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                line_q <= '0;
            end else if (cfg_we && wr_legal && (cfg_addr == CH_W'(c))) begin
                en_q   <= cfg_wdata[LINE_W];
                line_q <= wr_line;
            end
        end

        assign route_en[c]                      = en_q;
        assign route_line[c*LINE_W +: LINE_W]   = line_q;
    end

    assign cfg_rdata = {route_en[cfg_addr], route_line[cfg_addr*LINE_W +: LINE_W]};

endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
    import pirq_router_pkg::*;
#(
    parameter int NUM_CH   = DEF_NUM_SLOTS + 1,
    parameter int NUM_IRQ  = DEF_NUM_IRQ,
    parameter logic [NUM_IRQ-1:0] LEGAL_MASK = DEF_LEGAL_MASK,
    parameter int IDE_LINE = DEF_IDE_LINE,
    localparam int LINE_W  = $clog2(NUM_IRQ)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ide_on,
    input  logic [NUM_CH-1:0]        pirq,
    input  logic [NUM_CH-1:0]        route_en,
    input  logic [NUM_CH*LINE_W-1:0] route_line,
    output logic [NUM_IRQ-1:0]       irq_req
);

    logic [NUM_IRQ-1:0] line_open;
    logic [NUM_IRQ-1:0] req_nxt;

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_open
        if (k == IDE_LINE) begin : g_ide
            assign line_open[k] = LEGAL_MASK[k] & ~ide_on;
        end else begin : g_plain
            assign line_open[k] = LEGAL_MASK[k];
        end
    end

    always_comb begin
        req_nxt = '0;
        for (int k = 0; k < NUM_IRQ; k++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (pirq[c] && route_en[c] &&
                    (route_line[c*LINE_W +: LINE_W] == LINE_W'(k))) begin
                    req_nxt[k] = 1'b1;
                end
            end
        end
        req_nxt = req_nxt & line_open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_req <= '0;
        end else begin
            irq_req <= req_nxt;
        end
    end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int PINS      = DEF_PINS,
    parameter int NUM_IRQ   = DEF_NUM_IRQ,
    parameter logic [NUM_IRQ-1:0] LEGAL_MASK = DEF_LEGAL_MASK,
    parameter int IDE_LINE  = DEF_IDE_LINE,
    localparam int NUM_CH   = NUM_SLOTS + 1,
    localparam int NUM_PIN  = NUM_SLOTS * PINS,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int LINE_W   = $clog2(NUM_IRQ),
    localparam int RW       = LINE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PIN-1:0] slot_int_n,
    input  logic               scsi_int_n,
    input  logic               ide_on,
    input  logic               cfg_we,
    input  logic [CH_W-1:0]    cfg_addr,
    input  logic [RW-1:0]      cfg_wdata,
    output logic [RW-1:0]      cfg_rdata,
    output logic [NUM_IRQ-1:0] irq_req
);

    logic [NUM_CH-1:0]        pirq;
    logic [NUM_CH-1:0]        route_en;
    logic [NUM_CH*LINE_W-1:0] route_line;

    pirq_swizzle #(
        .NUM_SLOTS (NUM_SLOTS),
        .PINS      (PINS)
    ) u_swizzle (
        .slot_int_n (slot_int_n),
        .scsi_int_n (scsi_int_n),
        .pirq       (pirq)
    );

    pirq_route_regs #(
        .NUM_CH     (NUM_CH),
        .NUM_IRQ    (NUM_IRQ),
        .LEGAL_MASK (LEGAL_MASK),
        .IDE_LINE   (IDE_LINE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ide_on     (ide_on),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .route_en   (route_en),
        .route_line (route_line)
    );

    pirq_steer #(
        .NUM_CH     (NUM_CH),
        .NUM_IRQ    (NUM_IRQ),
        .LEGAL_MASK (LEGAL_MASK),
        .IDE_LINE   (IDE_LINE)
    ) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ide_on     (ide_on),
        .pirq       (pirq),
        .route_en   (route_en),
        .route_line (route_line),
        .irq_req    (irq_req)
    );

endmodule

// File: rtl/pirq_router_checker.sv
module pirq_router_checker #(
    parameter int NUM_CH   = 4,
    parameter int LINE_W   = 4,
    parameter int NUM_IRQ  = 16,
    parameter logic [NUM_IRQ-1:0] LEGAL_MASK = 16'hC620,
    parameter int IDE_LINE = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ide_on,
    input logic                     cfg_we,
    input logic [LINE_W:0]          cfg_wdata,
    input logic [NUM_CH-1:0]        route_en,
    input logic [NUM_CH*LINE_W-1:0] route_line,
    input logic [NUM_IRQ-1:0]       irq_req
);

    // R9: no request ever leaves on a line outside the legal set
    p_legal_lines_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~LEGAL_MASK) == '0);

    // R4: coming out of reset, routes are disabled and no request is raised
    p_reset_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (route_en == '0 && irq_req == '0));

    // R5: a write naming an illegal line leaves every route register unchanged
    p_bad_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !LEGAL_MASK[cfg_wdata[LINE_W-1:0]])
        |=> ($stable(route_en) && $stable(route_line)));

    // R6: line 14 cannot be programmed while IDE owns it
    p_ide_write_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && ide_on && cfg_wdata[LINE_W-1:0] == LINE_W'(IDE_LINE))
        |=> ($stable(route_en) && $stable(route_line)));

    // R6: line 14 stays quiet once IDE has owned it for a full cycle
    p_ide_line_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_on && $past(ide_on)) |-> !irq_req[IDE_LINE]);

    // R7: with every route disabled, nothing is driven in the next cycle
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(route_en == '0) |-> (irq_req == '0));

endmodule

bind pirq_router pirq_router_checker #(
    .NUM_CH     (NUM_CH),
    .LINE_W     (LINE_W),
    .NUM_IRQ    (NUM_IRQ),
    .LEGAL_MASK (LEGAL_MASK),
    .IDE_LINE   (IDE_LINE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ide_on     (ide_on),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .route_en   (route_en),
    .route_line (route_line),
    .irq_req    (irq_req)
);

// File: tb/pirq_router_test.sv
`timescale 1ns/1ps
module pirq_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] slot_int_n = 12'hFFF;
    logic        scsi_int_n = 1'b1;
    logic        ide_on = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [4:0]  cfg_wdata = 5'd0;
    logic [4:0]  cfg_rdata;
    logic [15:0] irq_req;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pirq_router uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_int_n (slot_int_n),
        .scsi_int_n (scsi_int_n),
        .ide_on     (ide_on),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .irq_req    (irq_req)
    );

    // routes used by the table: ch0->5, ch1->9, ch2->10, ch3->15
    // entry = {slot_int_n[11:0], scsi_int_n, expected irq_req[15:0]}
    localparam logic [28:0] VEC [16] = '{
        {12'hFFF, 1'b1, 16'h0000},  // idle
        {12'hFFE, 1'b1, 16'h0020},  // bit0  -> ch0
        {12'hFFD, 1'b1, 16'h0400},  // bit1  -> ch2
        {12'hFFB, 1'b1, 16'h0200},  // bit2  -> ch1
        {12'hFF7, 1'b1, 16'h0020},  // bit3  -> ch0
        {12'hFEF, 1'b1, 16'h0200},  // bit4  -> ch1
        {12'hFDF, 1'b1, 16'h0020},  // bit5  -> ch0
        {12'hFBF, 1'b1, 16'h0400},  // bit6  -> ch2
        {12'hF7F, 1'b1, 16'h0200},  // bit7  -> ch1
        {12'hEFF, 1'b1, 16'h0400},  // bit8  -> ch2
        {12'hDFF, 1'b1, 16'h0200},  // bit9  -> ch1
        {12'hBFF, 1'b1, 16'h0020},  // bit10 -> ch0
        {12'h7FF, 1'b1, 16'h0400},  // bit11 -> ch2
        {12'hFFF, 1'b0, 16'h8000},  // SCSI  -> ch3
        {12'hFF6, 1'b1, 16'h0020},  // bits 0 and 3 share ch0
        {12'h000, 1'b0, 16'h8620}   // everything
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] addr, input logic [4:0] data);
        @(negedge clk);
        cfg_addr  = addr;
        cfg_wdata = data;
        cfg_we    = 1'b1;
        @(posedge clk);
        #1;
        cfg_we    = 1'b0;
    endtask

    task automatic cfg_read_check(input string req, input logic [1:0] addr, input logic [4:0] exp);
        cfg_addr = addr;
        #1;
        check(req, {27'd0, cfg_rdata}, {27'd0, exp});
    endtask

    task automatic drive_and_check(input string req, input logic [11:0] slots,
                                   input logic scsi, input logic [15:0] exp);
        @(negedge clk);
        slot_int_n = slots;
        scsi_int_n = scsi;
        @(posedge clk);
        #1;
        check(req, {16'd0, irq_req}, {16'd0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R4: reset state with every source asserted
        slot_int_n = 12'h000;
        scsi_int_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R4 irq_req in reset", {16'd0, irq_req}, 32'd0);
        for (int a = 0; a < 4; a++) cfg_read_check("R4 route reset value", 2'(a), 5'h00);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: all routes disabled after reset, sources still asserted
        repeat (2) @(posedge clk);
        #1;
        check("R7 nothing driven before enable", {16'd0, irq_req}, 32'd0);
        slot_int_n = 12'hFFF;
        scsi_int_n = 1'b1;

        // R3: program and read back
        cfg_write(2'd0, 5'h15);
        cfg_write(2'd1, 5'h19);
        cfg_write(2'd2, 5'h1A);
        cfg_write(2'd3, 5'h1F);
        cfg_read_check("R3 readback ch0", 2'd0, 5'h15);
        cfg_read_check("R3 readback ch1", 2'd1, 5'h19);
        cfg_read_check("R3 readback ch2", 2'd2, 5'h1A);
        cfg_read_check("R3 readback ch3", 2'd3, 5'h1F);

        // R1 / R2: rotation table
        for (int i = 0; i < 16; i++) begin
            drive_and_check((i == 13) ? "R2 SCSI channel" : "R1 swizzle vector",
                            VEC[i][28:17], VEC[i][16], VEC[i][15:0]);
        end
        drive_and_check("R10 release drops request", 12'hFFF, 1'b1, 16'h0000);

        // R5: illegal targets are ignored, including the enable bit
        cfg_write(2'd0, 5'h18);
        cfg_read_check("R5 line 8 rejected", 2'd0, 5'h15);
        cfg_write(2'd0, 5'h1D);
        cfg_read_check("R5 line 13 rejected", 2'd0, 5'h15);
        cfg_write(2'd0, 5'h12);
        cfg_read_check("R5 line 2 rejected", 2'd0, 5'h15);
        cfg_write(2'd0, 5'h03);
        cfg_read_check("R5 disable with illegal line rejected", 2'd0, 5'h15);
        drive_and_check("R5 ch0 still routes to 5", 12'hFFE, 1'b1, 16'h0020);
        drive_and_check("R9 idle", 12'hFFF, 1'b1, 16'h0000);

        // R6: line 14 and the IDE function
        ide_on = 1'b1;
        cfg_write(2'd1, 5'h1E);
        cfg_read_check("R6 line 14 rejected under IDE", 2'd1, 5'h19);
        ide_on = 1'b0;
        cfg_write(2'd1, 5'h1E);
        cfg_read_check("R6 line 14 accepted without IDE", 2'd1, 5'h1E);
        drive_and_check("R6 ch1 drives line 14", 12'hFEF, 1'b1, 16'h4000);
        @(negedge clk);
        ide_on = 1'b1;
        @(posedge clk);
        #1;
        check("R6 line 14 masked under IDE", {16'd0, irq_req}, 32'd0);
        @(negedge clk);
        ide_on = 1'b0;
        drive_and_check("R6 idle", 12'hFFF, 1'b1, 16'h0000);

        // R8: two channels on one line
        cfg_write(2'd2, 5'h15);
        drive_and_check("R8 ch0 and ch2 both on 5", 12'hEFE, 1'b1, 16'h0020);
        drive_and_check("R8 ch2 alone on 5", 12'hEFF, 1'b1, 16'h0020);
        drive_and_check("R10 level release", 12'hFFF, 1'b1, 16'h0000);

        // R10: one clock of latency
        @(negedge clk);
        slot_int_n = 12'hFFE;
        #1;
        check("R10 no change before edge", {16'd0, irq_req}, 32'd0);
        @(posedge clk);
        #1;
        check("R10 change after edge", {16'd0, irq_req}, 32'h0020);
        drive_and_check("R10 idle", 12'hFFF, 1'b1, 16'h0000);

        // R7: disabled channel with a legal line
        cfg_write(2'd3, 5'h0F);
        cfg_read_check("R7 disable accepted", 2'd3, 5'h0F);
        drive_and_check("R7 disabled SCSI channel quiet", 12'hFFF, 1'b0, 16'h0000);
        drive_and_check("R9 all sources, legal lines only", 12'h000, 1'b0, 16'h4020);

        // R4: reset again clears routes asynchronously
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R4 async clear of irq_req", {16'd0, irq_req}, 32'd0);
        for (int a = 0; a < 4; a++) cfg_read_check("R4 routes cleared", 2'(a), 5'h00);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R7 quiet after second reset", {16'd0, irq_req}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule